// File: doc/BRIEF.md
# IDE DMA Transfer Sequencer

This block steers one bus-master DMA transfer between a drive (a fixed disk or a packet-command optical drive) and a descriptor-driven DMA channel. A start pulse arms the sequencer. It latches the command, the device kind and the starting block address. It also loads a remaining-byte count and clears a byte-progress index. After that, the DMA channel hands over chunks, one at a time. For each chunk the sequencer decides one of four things: park the chunk, close the chunk alone, close the whole drive transfer, or issue one storage request for the chunk.

Storage access is outside the block. It sits behind a request/acknowledge port that carries an operation code, a byte address and a length. The acknowledge comes back with an error flag. A good acknowledge advances the counters and closes the chunk. A failed one ends the transfer. When the transfer ends, the status byte is updated and an interrupt pulse is raised. For optical drives there is a special case: a block address of all ones means the data is already buffered. That data is copied straight out instead of being fetched.

Top module: `ide_dma_seq`

## Requirements
- R1: After reset, `busy_o` is 0, `status_o` is 8'h00, and `st_req_o`, `irq_o`, `chunk_done_o`, `chunk_park_o`, `copy_o`, `cmd_err_o` and `xfer_err_o` are all 0.
- R2: A start pulse taken while no storage request is outstanding does the following: it sets `busy_o`, sets `status_o` to 8'h80 (bit 7 = busy), and clears the progress index. It loads the remaining count with `nsec_i` × 512 for a disk (`optical_i`=0) or with `pkt_i` for an optical drive (`optical_i`=1).
- R3: A chunk that arrives while `busy_o` is 0 produces only a one-cycle `chunk_park_o` pulse. It causes no request, no `chunk_done_o` and no interrupt.
- R4: When a chunk of length zero arrives on an armed transfer that still has bytes remaining, only `chunk_done_o` pulses, and `busy_o` stays 1.
- R5: The request address is start block × 512 + progress index for a disk, and start block × 2048 + progress index for an optical drive.
- R6: On an acknowledge without error, `chunk_done_o` pulses and `st_req_o` falls. The remaining count drops by the chunk length and the index rises by it.
- R7: An armed chunk is judged in this order: remaining count ≤ 0, then zero length, then optical all-ones block, then bad command, then request. If the remaining count is ≤ 0, the transfer completes: `status_o` becomes 8'h50 (bit 6 ready, bit 4 seek done), `irq_o` and `chunk_done_o` pulse, and `busy_o` clears.
- R8: On an optical transfer whose start block is all ones, a chunk with a non-zero length pulses `copy_o`. It sets `copy_len_o` to the smaller of the remaining count and the chunk length, makes no storage request, and completes as in R7.
- R9: An acknowledge with `st_err_i`=1 pulses `xfer_err_o`, `irq_o` and `chunk_done_o`. It sets `status_o` to 8'h41 (bit 6 ready, bit 0 error) and clears `busy_o`.
- R10: `st_op_o` codes are 0 read, 1 write and 2 trim. A disk uses `cmd_i` as latched at start. An optical drive always reads. A disk command of 3 issues no request: instead `cmd_err_o`, `chunk_done_o` and `irq_o` pulse, `status_o` becomes 8'h41, and `busy_o` clears.
- R11: While `st_req_o` is 1 and no acknowledge has come, `st_req_o`, `st_addr_o`, `st_len_o` and `st_op_o` hold their values.
- R12: A chunk offered in the same cycle as a start pulse is dropped with no output pulse. A start pulse that arrives while a request is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Arm a new transfer |
| optical_i | input | 1 | 1 = packet (optical) drive, 0 = disk |
| cmd_i | input | 2 | Disk command: 0 read, 1 write, 2 trim, 3 invalid |
| nsec_i | input | SEC_W | Disk sector count |
| pkt_i | input | SEC_W+9 | Optical transfer size in bytes |
| lba_i | input | LBA_W | Start block address |
| chunk_valid_i | input | 1 | DMA chunk offered (single-cycle) |
| chunk_len_i | input | LEN_W | Chunk length in bytes |
| chunk_done_o | output | 1 | Chunk finished pulse |
| chunk_park_o | output | 1 | Chunk parked, transfer not armed |
| st_req_o | output | 1 | Storage request pending |
| st_op_o | output | 2 | Storage operation code |
| st_addr_o | output | LBA_W+12 | Storage byte address |
| st_len_o | output | LEN_W | Storage request length |
| st_ack_i | input | 1 | Storage acknowledge |
| st_err_i | input | 1 | Storage error, valid with acknowledge |
| copy_o | output | 1 | Buffered copy-out pulse |
| copy_len_o | output | LEN_W | Copy-out length |
| busy_o | output | 1 | Transfer armed |
| status_o | output | 8 | Drive status byte |
| irq_o | output | 1 | Completion interrupt pulse |
| cmd_err_o | output | 1 | Invalid command pulse |
| xfer_err_o | output | 1 | Storage error pulse |

## Verification
Arming and chunk handling can land in the same cycle in two ways. A start pulse can coincide with a chunk offer. A start pulse can also arrive while a request still waits for its acknowledge. The bench drives both on purpose. In the first case it expects no pulse of any kind, and then checks that the next chunk is addressed at the new start block with a zero index. In the second case it acknowledges the pending request and checks that the next request address includes the first chunk's length. That shows the stray start neither reloaded the counters nor disturbed the held request.

// File: rtl/ide_seq_pkg.sv
// Package: shared types and status codes for the DMA transfer sequencer.
// Assumes: status bit positions follow the usual ATA status byte layout.
package ide_seq_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_TRIM  = 2'd2,
        OP_BAD   = 2'd3
    } op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } seq_state_e;

    localparam logic [7:0] STAT_BUSY = 8'h80;
    localparam logic [7:0] STAT_OK   = 8'h50;
    localparam logic [7:0] STAT_ERR  = 8'h41;

endpackage

// File: rtl/ide_seq_cnt.sv
// Module: remaining-byte and progress-index counters.
// Does: loads the byte budget at start and steps both counters by a chunk length.
// Assumes: CNT_W >= SEC_W + 9 so that a full sector count fits in bytes.
module ide_seq_cnt #(
    parameter int SEC_W = 16,
    parameter int CNT_W = 25,
    parameter int LEN_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  logic                    optical_i,
    input  logic [SEC_W-1:0]        nsec_i,
    input  logic [CNT_W-1:0]        pkt_i,
    input  logic                    upd_i,
    input  logic [LEN_W-1:0]        len_i,
    output logic signed [CNT_W:0]   rem_o,
    output logic [CNT_W-1:0]        idx_o,
    output logic                    drained_o
);

    logic [CNT_W:0] sec_bytes;
    logic [CNT_W:0] len_ext;

    // Byte budget of a disk command and the chunk length at counter width.
    assign sec_bytes = (CNT_W+1)'(nsec_i) << 9;
    assign len_ext   = (CNT_W+1)'(len_i);

    // Load at start, then step down the budget and up the index per good chunk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_o <= '0;
            idx_o <= '0;
        end else if (load_i) begin
            rem_o <= optical_i ? $signed({1'b0, pkt_i}) : $signed(sec_bytes);
            idx_o <= '0;
        end else if (upd_i) begin
            rem_o <= rem_o - $signed(len_ext);
            idx_o <= idx_o + CNT_W'(len_i);
        end
    end

    // The drive side is finished once nothing positive remains.
    assign drained_o = rem_o[CNT_W] || (rem_o == '0);

    p_idx_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !load_i) |=> (idx_o == $past(idx_o) + CNT_W'($past(len_i))));

    p_rem_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !load_i) |=> (rem_o == $past(rem_o) - $signed((CNT_W+1)'($past(len_i)))));

    p_load_idx_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (idx_o == '0));

endmodule

// File: rtl/ide_seq_addr.sv
// Module: storage byte address generator.
// Does: scales the start block by 512 (disk) or 2048 (optical) and adds the index.
// Assumes: ADDR_W >= LBA_W + 12 so neither scaling nor the add can overflow.
module ide_seq_addr #(
    parameter int LBA_W  = 28,
    parameter int CNT_W  = 25,
    parameter int ADDR_W = 40
) (
    input  logic [LBA_W-1:0]  lba_i,
    input  logic [CNT_W-1:0]  idx_i,
    input  logic              optical_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              all_ones_o
);

    logic [ADDR_W-1:0] base;

    // Block-size scaling picked by the device kind.
    assign base = optical_i ? (ADDR_W'(lba_i) << 11) : (ADDR_W'(lba_i) << 9);

    // Byte address of the next chunk.
    assign addr_o = base + ADDR_W'(idx_i);

    // All-ones block marks already-buffered optical data.
    assign all_ones_o = &lba_i;

endmodule

// File: rtl/ide_dma_seq.sv
// Module: IDE DMA transfer sequencer (top).
// Does: arms a transfer, judges each offered DMA chunk, issues storage requests,
//       and closes the transfer with status and interrupt on end or error.
// Assumes: chunk_valid_i is a single-cycle offer; st_err_i is valid only with
//          st_ack_i; the request port is held until acknowledged.
module ide_dma_seq
    import ide_seq_pkg::*;
#(
    parameter int LBA_W = 28,
    parameter int SEC_W = 16,
    parameter int LEN_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic                     optical_i,
    input  logic [1:0]               cmd_i,
    input  logic [SEC_W-1:0]         nsec_i,
    input  logic [SEC_W+8:0]         pkt_i,
    input  logic [LBA_W-1:0]         lba_i,
    input  logic                     chunk_valid_i,
    input  logic [LEN_W-1:0]         chunk_len_i,
    output logic                     chunk_done_o,
    output logic                     chunk_park_o,
    output logic                     st_req_o,
    output logic [1:0]               st_op_o,
    output logic [LBA_W+11:0]        st_addr_o,
    output logic [LEN_W-1:0]         st_len_o,
    input  logic                     st_ack_i,
    input  logic                     st_err_i,
    output logic                     copy_o,
    output logic [LEN_W-1:0]         copy_len_o,
    output logic                     busy_o,
    output logic [7:0]               status_o,
    output logic                     irq_o,
    output logic                     cmd_err_o,
    output logic                     xfer_err_o
);

    localparam int CNT_W  = SEC_W + 9;
    localparam int ADDR_W = LBA_W + 12;

    seq_state_e            state;
    op_e                   cmd_q;
    logic                  opt_q;
    logic [LBA_W-1:0]      lba_q;
    logic                  load;
    logic                  upd;
    logic signed [CNT_W:0] rem;
    logic [CNT_W-1:0]      idx;
    logic                  drained;
    logic [ADDR_W-1:0]     addr;
    logic                  all_ones;
    logic [LEN_W-1:0]      copy_len;

    // Arming is taken only when no request is outstanding; a good ack steps counters.
    assign load = start_i && (state == ST_IDLE);
    assign upd  = (state == ST_WAIT) && st_ack_i && !st_err_i;

    ide_seq_cnt #(.SEC_W(SEC_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .optical_i (optical_i),
        .nsec_i    (nsec_i),
        .pkt_i     (pkt_i),
        .upd_i     (upd),
        .len_i     (st_len_o),
        .rem_o     (rem),
        .idx_o     (idx),
        .drained_o (drained)
    );

    ide_seq_addr #(.LBA_W(LBA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_addr (
        .lba_i      (lba_q),
        .idx_i      (idx),
        .optical_i  (opt_q),
        .addr_o     (addr),
        .all_ones_o (all_ones)
    );

    // Copy-out length: the smaller of what remains and what the chunk offers.
    assign copy_len = ($unsigned(rem) < (CNT_W+1)'(chunk_len_i)) ? rem[LEN_W-1:0] : chunk_len_i;

    // Sequencer: arming, per-chunk decision chain and acknowledge handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            cmd_q        <= OP_READ;
            opt_q        <= 1'b0;
            lba_q        <= '0;
            busy_o       <= 1'b0;
            status_o     <= 8'h00;
            st_req_o     <= 1'b0;
            st_op_o      <= 2'd0;
            st_addr_o    <= '0;
            st_len_o     <= '0;
            copy_len_o   <= '0;
            chunk_done_o <= 1'b0;
            chunk_park_o <= 1'b0;
            copy_o       <= 1'b0;
            irq_o        <= 1'b0;
            cmd_err_o    <= 1'b0;
            xfer_err_o   <= 1'b0;
        end else begin
            chunk_done_o <= 1'b0;
            chunk_park_o <= 1'b0;
            copy_o       <= 1'b0;
            irq_o        <= 1'b0;
            cmd_err_o    <= 1'b0;
            xfer_err_o   <= 1'b0;
            if (load) begin
                cmd_q    <= op_e'(cmd_i);
                opt_q    <= optical_i;
                lba_q    <= lba_i;
                busy_o   <= 1'b1;
                status_o <= STAT_BUSY;
            end else if (state == ST_IDLE) begin
                if (chunk_valid_i) begin
                    if (!busy_o) begin
                        chunk_park_o <= 1'b1;
                    end else if (drained) begin
                        busy_o       <= 1'b0;
                        status_o     <= STAT_OK;
                        irq_o        <= 1'b1;
                        chunk_done_o <= 1'b1;
                    end else if (chunk_len_i == '0) begin
                        chunk_done_o <= 1'b1;
                    end else if (opt_q && all_ones) begin
                        copy_o       <= 1'b1;
                        copy_len_o   <= copy_len;
                        busy_o       <= 1'b0;
                        status_o     <= STAT_OK;
                        irq_o        <= 1'b1;
                        chunk_done_o <= 1'b1;
                    end else if (!opt_q && (cmd_q == OP_BAD)) begin
                        cmd_err_o    <= 1'b1;
                        busy_o       <= 1'b0;
                        status_o     <= STAT_ERR;
                        irq_o        <= 1'b1;
                        chunk_done_o <= 1'b1;
                    end else begin
                        st_req_o  <= 1'b1;
                        st_op_o   <= opt_q ? OP_READ : cmd_q;
                        st_addr_o <= addr;
                        st_len_o  <= chunk_len_i;
                        state     <= ST_WAIT;
                    end
                end
            end else if (st_ack_i) begin
                st_req_o     <= 1'b0;
                chunk_done_o <= 1'b1;
                state        <= ST_IDLE;
                if (st_err_i) begin
                    xfer_err_o <= 1'b1;
                    busy_o     <= 1'b0;
                    status_o   <= STAT_ERR;
                    irq_o      <= 1'b1;
                end
            end
        end
    end

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req_o && !st_ack_i) |=> (st_req_o && $stable(st_addr_o) && $stable(st_len_o) && $stable(st_op_o)));

    p_irq_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (!busy_o && !st_req_o && chunk_done_o));

    p_park_alone_r3: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_park_o |-> (!busy_o && !chunk_done_o && !irq_o && !st_req_o));

    p_cmd_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err_o |-> (chunk_done_o && irq_o && !st_req_o && status_o == STAT_ERR));

    p_xfer_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_err_o |-> ($fell(st_req_o) && status_o == STAT_ERR));

    p_copy_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        copy_o |-> (copy_len_o != '0 && !busy_o));

    p_done_drops_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req_o && st_ack_i) |=> (!st_req_o && chunk_done_o));

endmodule

// File: tb/ide_dma_seq_test.sv
`timescale 1ns/1ps
module ide_dma_seq_test;

    localparam int LBA_W = 28;
    localparam int SEC_W = 16;
    localparam int LEN_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              optical_i = 1'b0;
    logic [1:0]        cmd_i = 2'd0;
    logic [SEC_W-1:0]  nsec_i = '0;
    logic [SEC_W+8:0]  pkt_i = '0;
    logic [LBA_W-1:0]  lba_i = '0;
    logic              chunk_valid_i = 1'b0;
    logic [LEN_W-1:0]  chunk_len_i = '0;
    logic              st_ack_i = 1'b0;
    logic              st_err_i = 1'b0;
    logic              chunk_done_o, chunk_park_o, st_req_o, copy_o, busy_o;
    logic              irq_o, cmd_err_o, xfer_err_o;
    logic [1:0]        st_op_o;
    logic [LBA_W+11:0] st_addr_o;
    logic [LEN_W-1:0]  st_len_o, copy_len_o;
    logic [7:0]        status_o;

    int nchk = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    ide_dma_seq #(.LBA_W(LBA_W), .SEC_W(SEC_W), .LEN_W(LEN_W)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .optical_i(optical_i),
        .cmd_i(cmd_i), .nsec_i(nsec_i), .pkt_i(pkt_i), .lba_i(lba_i),
        .chunk_valid_i(chunk_valid_i), .chunk_len_i(chunk_len_i),
        .chunk_done_o(chunk_done_o), .chunk_park_o(chunk_park_o),
        .st_req_o(st_req_o), .st_op_o(st_op_o), .st_addr_o(st_addr_o),
        .st_len_o(st_len_o), .st_ack_i(st_ack_i), .st_err_i(st_err_i),
        .copy_o(copy_o), .copy_len_o(copy_len_o), .busy_o(busy_o),
        .status_o(status_o), .irq_o(irq_o), .cmd_err_o(cmd_err_o),
        .xfer_err_o(xfer_err_o)
    );

    typedef struct packed {
        logic [15:0] nsec;
        logic [27:0] lba;
        logic [1:0]  cmd;
        logic [15:0] len;
    } vec_t;

    localparam vec_t VECS [0:3] = '{
        '{16'd1, 28'd5,         2'd0, 16'd512},
        '{16'd4, 28'h0ABCDEF,   2'd1, 16'd256},
        '{16'd2, 28'd0,         2'd2, 16'd100},
        '{16'd1, 28'hFFFFFFE,   2'd0, 16'd600}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic arm(input logic opt, input logic [1:0] cmd, input logic [15:0] nsec,
                       input logic [24:0] pkt, input logic [27:0] lba);
        optical_i = opt; cmd_i = cmd; nsec_i = nsec; pkt_i = pkt; lba_i = lba;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic chunk(input logic [15:0] len);
        chunk_valid_i = 1'b1; chunk_len_i = len;
        @(negedge clk);
        chunk_valid_i = 1'b0;
    endtask

    task automatic ack(input logic err);
        st_ack_i = 1'b1; st_err_i = err;
        @(negedge clk);
        st_ack_i = 1'b0; st_err_i = 1'b0;
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 busy", busy_o, 0);
        chk("R1 status", status_o, 8'h00);
        chk("R1 pulses", {st_req_o, irq_o, chunk_done_o, chunk_park_o, copy_o, cmd_err_o, xfer_err_o}, 0);

        // R3: chunk with nothing armed parks
        chunk(16'd64);
        chk("R3 park", chunk_park_o, 1);
        chk("R3 no other", {chunk_done_o, st_req_o, irq_o}, 0);

        // Vector table: disk commands, addresses and second-chunk outcome
        for (int v = 0; v < 4; v++) begin
            logic [63:0] base;
            logic [63:0] total;
            base  = 64'(VECS[v].lba) << 9;
            total = 64'(VECS[v].nsec) * 512;
            arm(1'b0, VECS[v].cmd, VECS[v].nsec, 25'd0, VECS[v].lba);
            chk("R2 busy status", {busy_o, status_o}, {1'b1, 8'h80});
            chunk(VECS[v].len);
            chk("R5 disk addr", st_addr_o, base);
            chk("R10 op code", st_op_o, VECS[v].cmd);
            chk("R11 req len", {st_req_o, st_len_o}, {1'b1, VECS[v].len});
            ack(1'b0);
            chk("R6 chunk done", {chunk_done_o, st_req_o, busy_o}, 3'b101);
            chunk(VECS[v].len);
            if (64'(VECS[v].len) >= total) begin
                chk("R7 complete", {irq_o, chunk_done_o, busy_o, status_o}, {3'b110, 8'h50});
            end else begin
                chk("R6 next addr", st_addr_o, base + 64'(VECS[v].len));
                ack(1'b0);
            end
        end

        // R4: zero-length chunk closes only the chunk
        arm(1'b0, 2'd0, 16'd1, 25'd0, 28'd7);
        chunk(16'd0);
        chk("R4 zero len", {chunk_done_o, busy_o, st_req_o, irq_o}, 4'b1100);

        // R2/R7: exact disk budget 512 = 300 + 212, then a further chunk ends it
        chunk(16'd300);
        ack(1'b0);
        chunk(16'd212);
        chk("R6 second addr", st_addr_o, (64'd7 << 9) + 64'd300);
        ack(1'b0);
        chk("R2 still busy", busy_o, 1);
        chunk(16'd10);
        chk("R7 budget end", {irq_o, busy_o, st_req_o, status_o}, {3'b100, 8'h50});

        // R5/R10/R2: optical scaling, forced read op, packet-size budget
        arm(1'b1, 2'd3, 16'd0, 25'd2048, 28'd3);
        chunk(16'd1000);
        chk("R5 optical addr", st_addr_o, 64'd6144);
        chk("R10 optical read", st_op_o, 0);
        ack(1'b0);
        chunk(16'd1048);
        chk("R5 optical index", st_addr_o, 64'd7144);
        ack(1'b0);
        chunk(16'd1);
        chk("R7 optical end", {irq_o, busy_o, status_o}, {2'b10, 8'h50});

        // R8: all-ones block copies out, remaining smaller than chunk
        arm(1'b1, 2'd0, 16'd0, 25'd200, {LBA_W{1'b1}});
        chunk(16'd512);
        chk("R8 copy short", {copy_o, copy_len_o, st_req_o}, {1'b1, 16'd200, 1'b0});
        chk("R8 completes", {irq_o, busy_o, status_o}, {2'b10, 8'h50});
        // R8: remaining larger than chunk
        arm(1'b1, 2'd0, 16'd0, 25'd700, {LBA_W{1'b1}});
        chunk(16'd512);
        chk("R8 copy chunk", {copy_o, copy_len_o}, {1'b1, 16'd512});

        // R9: storage error ends the transfer
        arm(1'b0, 2'd1, 16'd2, 25'd0, 28'd9);
        chunk(16'd512);
        ack(1'b1);
        chk("R9 error", {xfer_err_o, irq_o, chunk_done_o, busy_o, st_req_o}, 5'b11100);
        chk("R9 status", status_o, 8'h41);

        // R10: invalid disk command
        arm(1'b0, 2'd3, 16'd2, 25'd0, 28'd9);
        chunk(16'd512);
        chk("R10 bad cmd", {cmd_err_o, chunk_done_o, irq_o, st_req_o, busy_o}, 5'b11100);
        chk("R10 status", status_o, 8'h41);

        // R11/R12: request held; start during wait ignored
        arm(1'b0, 2'd0, 16'd4, 25'd0, 28'd20);
        chunk(16'd512);
        repeat (2) @(negedge clk);
        start_i = 1'b1; lba_i = 28'd99; nsec_i = 16'd1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R11 held", {st_req_o, st_addr_o}, {1'b1, 40'(64'd20 << 9)});
        ack(1'b0);
        chunk(16'd512);
        chk("R12 start ignored", st_addr_o, (64'd20 << 9) + 64'd512);
        ack(1'b0);

        // R12: start and chunk in the same cycle, chunk dropped
        optical_i = 1'b0; cmd_i = 2'd0; nsec_i = 16'd2; lba_i = 28'd40;
        start_i = 1'b1; chunk_valid_i = 1'b1; chunk_len_i = 16'd128;
        @(negedge clk);
        start_i = 1'b0; chunk_valid_i = 1'b0;
        chk("R12 collide", {busy_o, chunk_done_o, chunk_park_o, st_req_o, irq_o}, 5'b10000);
        chunk(16'd128);
        chk("R12 fresh index", {st_req_o, st_addr_o}, {1'b1, 40'(64'd40 << 9)});
        ack(1'b0);

        finish_run();
    end

endmodule